// File: doc/BRIEF.md
# Switch-Addressed SRAM Word Reader with Hex Display

This block reads one 16-bit word from an external asynchronous static RAM and shows it as four hexadecimal digits on seven-segment displays. Five switch inputs pick one of 32 word locations. The block widens that 5-bit value to the memory's 18-bit address by holding the upper lines at zero. A slow clock, pulsed by hand, steps the read. Each edge copies the word that the memory is driving into a holding register, and the displays show that register.

The block only reads. Its write strobe stays inactive, and its side of the shared bidirectional data bus is always in high impedance. After a synchronous active-low reset, the block starts idle: every strobe is off and the register holds zero. The first clock edge after reset turns on the chip, output and byte strobes, and reads nothing. Every later edge captures a word.

Top module: `sram_hex_reader`

## Requirements
- R1: `mem_addr[4:0]` always equals `sw_addr`, and `mem_addr[17:5]` is always zero.
- R2: `mem_we_n` is always 1.
- R3: The block never drives `mem_dq`. The word it captures is exactly the word the memory places on the bus.
- R4: An edge with `rst_n` low leaves the block idle. All four strobes are 1 and the held word is 0x0000, so every digit shows the zero glyph (active-low 7'b1000000).
- R5: The first edge after reset is released only sets the four strobes to 0. The display does not change at that edge, and it does not change at any edge where the strobes were 1.
- R6: Once the strobes are active, each clock edge captures the word at the switch address present just before that edge, and the display shows it after that edge.
- R7: Each digit is an active-low 7-bit pattern with bit 0 = segment a through bit 6 = segment g. The ten numerals use the usual shapes. Values 10 to 15 show the letter glyphs A, b, C, d, E, F, whose active-high gfedcba codes are 77, 7C, 39, 5E, 79, 71 in hex.
- R8: `disp_seg_n[7*k+6:7*k]` shows nibble k of the held word, so digit 0 is bits 3:0 and digit 3 is bits 15:12.
- R9: `mem_ce_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` always carry the same value, so both bytes are enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Hand-pulsed step clock; each rising edge advances the block |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_addr | input | 5 | Word location selected on the switches |
| mem_addr | output | 18 | Address lines to the memory |
| mem_dq | inout | 16 | Shared data bus; the block only listens |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, held inactive |
| mem_lb_n | output | 1 | Low-byte enable, active low |
| mem_ub_n | output | 1 | High-byte enable, active low |
| disp_seg_n | output | 28 | Four active-low segment patterns, digit 0 in bits 6:0 |

## Verification
The only internal state is the idle/active flag and the held word, and each shows at the ports on the edge that changes it. If the flag is wrong, the strobes are wrong at once, or the display picks up a word on the edge right after reset, where it should stay at zero. If the held word or a nibble's route to its digit is wrong, a wrong glyph shows on the sample after the capture edge. Sweeping all 32 locations, filled with words that put every nibble value in every digit position, exposes both a bad capture and a swapped digit within one edge.

// File: rtl/sram_hex_pkg.sv
// Package: types and sizes shared by the SRAM word reader.
// Assumes: one idle state and one reading state are enough, because the
// memory is asynchronous and answers within one hand-pulsed period.
package sram_hex_pkg;

    // Read controller phase
    typedef enum logic {
        RD_IDLE   = 1'b0,
        RD_ACTIVE = 1'b1
    } rd_phase_t;

    localparam int NIBBLE_W = 4;
    localparam int SEG_W    = 7;

endpackage

// File: rtl/srh_addr_map.sv
// srh_addr_map: widens the switch address to the full memory address.
// Assumes: SW_W <= ADDR_W; the unused high lines are tied to zero.
module srh_addr_map #(
    parameter int SW_W   = 5,
    parameter int ADDR_W = 18
) (
    input  logic [SW_W-1:0]   sw,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - SW_W;

    generate
        if (PAD_W > 0) begin : g_pad
            // zero the high lines and pass the switches through
            assign addr = {{PAD_W{1'b0}}, sw};
        end else begin : g_nopad
            // switches cover the whole address
            assign addr = sw;
        end
    endgenerate
endmodule

// File: rtl/srh_read_ctrl.sv
// srh_read_ctrl: turns the read strobes on and captures bus words.
// Assumes: clk is a slow step clock, so the asynchronous memory has settled
// long before the capture edge; rst_n is synchronous and active low.
module srh_read_ctrl
    import sram_hex_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic              strobe_n,
    output logic [DATA_W-1:0] word_q
);
    rd_phase_t phase_q;

    // phase register and captured word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= RD_IDLE;
            word_q  <= '0;
        end else begin
            case (phase_q)
                RD_IDLE:   phase_q <= RD_ACTIVE;
                RD_ACTIVE: word_q  <= bus_in;
                default:   phase_q <= RD_IDLE;
            endcase
        end
    end

    // strobes are active only while reading
    always_comb begin
        strobe_n = (phase_q != RD_ACTIVE);
    end
endmodule

// File: rtl/srh_seg_decode.sv
// srh_seg_decode: one hex nibble to an active-low seven-segment pattern.
// Assumes: bit 0 drives segment a and bit 6 drives segment g.
module srh_seg_decode
    import sram_hex_pkg::*;
(
    input  logic [NIBBLE_W-1:0] nibble,
    output logic [SEG_W-1:0]    seg_n
);
    logic [SEG_W-1:0] lit;  // active-high, bit order gfedcba

    // pick the lit segments for each digit value
    always_comb begin
        case (nibble)
            4'h0:    lit = 7'b0111111;
            4'h1:    lit = 7'b0000110;
            4'h2:    lit = 7'b1011011;
            4'h3:    lit = 7'b1001111;
            4'h4:    lit = 7'b1100110;
            4'h5:    lit = 7'b1101101;
            4'h6:    lit = 7'b1111101;
            4'h7:    lit = 7'b0000111;
            4'h8:    lit = 7'b1111111;
            4'h9:    lit = 7'b1101111;
            4'hA:    lit = 7'b1110111;
            4'hB:    lit = 7'b1111100;
            4'hC:    lit = 7'b0111001;
            4'hD:    lit = 7'b1011110;
            4'hE:    lit = 7'b1111001;
            default: lit = 7'b1110001;
        endcase
        seg_n = ~lit;
    end
endmodule

// File: rtl/sram_hex_reader.sv
// sram_hex_reader: reads one word from an asynchronous SRAM at a
// switch-selected location and shows it as hex digits.
// Assumes: read-only use; the bus is never driven from this side; DATA_W
// is a multiple of four.
module sram_hex_reader
    import sram_hex_pkg::*;
#(
    parameter int SW_W   = 5,
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SW_W-1:0]                sw_addr,
    output logic [ADDR_W-1:0]              mem_addr,
    inout  wire  [DATA_W-1:0]              mem_dq,
    output logic                           mem_ce_n,
    output logic                           mem_oe_n,
    output logic                           mem_we_n,
    output logic                           mem_lb_n,
    output logic                           mem_ub_n,
    output logic [(DATA_W/4)*SEG_W-1:0]    disp_seg_n
);
    localparam int DIGITS = DATA_W / NIBBLE_W;

    logic              strobe_n;
    logic [DATA_W-1:0] word_q;

    // bus stays released: this side only listens
    assign mem_dq = {DATA_W{1'bz}};

    srh_addr_map #(.SW_W(SW_W), .ADDR_W(ADDR_W)) u_addr (
        .sw   (sw_addr),
        .addr (mem_addr)
    );

    srh_read_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (mem_dq),
        .strobe_n (strobe_n),
        .word_q   (word_q)
    );

    // one strobe source fans out to all read enables; write stays off
    always_comb begin
        mem_ce_n = strobe_n;
        mem_oe_n = strobe_n;
        mem_lb_n = strobe_n;
        mem_ub_n = strobe_n;
        mem_we_n = 1'b1;
    end

    generate
        for (genvar d = 0; d < DIGITS; d++) begin : g_digit
            srh_seg_decode u_dec (
                .nibble (word_q[d*NIBBLE_W +: NIBBLE_W]),
                .seg_n  (disp_seg_n[d*SEG_W +: SEG_W])
            );
        end
    endgenerate
endmodule

// File: rtl/srh_checker.sv
// srh_checker: port-level properties of sram_hex_reader, bound to it below.
// Assumes: rst_n is low from time zero until the first edges have passed.
module srh_checker #(
    parameter int SW_W   = 5,
    parameter int ADDR_W = 18,
    parameter int DISP_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SW_W-1:0]   sw_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic [DISP_W-1:0] disp_seg_n
);
    // R1: switches on the low lines, zeros above
    assert_addr_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr == {{(ADDR_W-SW_W){1'b0}}, sw_addr}));

    // R2: write strobe never asserted
    assert_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_n);

    // R9: the four read strobes move together
    assert_strobes_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce_n == mem_oe_n) && (mem_ce_n == mem_lb_n) && (mem_ce_n == mem_ub_n));

    // R5: an edge seen with strobes off captures nothing
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |=> $stable(disp_seg_n));

    // R5: the edge that turns the strobes on leaves the display alone
    assert_arm_no_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> $stable(disp_seg_n));
endmodule

bind sram_hex_reader srh_checker #(
    .SW_W   (SW_W),
    .ADDR_W (ADDR_W),
    .DISP_W ((DATA_W/4)*7)
) i_srh_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_addr    (sw_addr),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ub_n   (mem_ub_n),
    .disp_seg_n (disp_seg_n)
);

// File: tb/test_sram_hex_reader.sv
// Directed bench for sram_hex_reader with a 32-word combinational SRAM model.
module test_sram_hex_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  sw_addr = '0;
    logic [17:0] mem_addr;
    wire  [15:0] mem_dq;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [27:0] disp_seg_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] mem [0:31];
    logic [15:0] model_word;
    logic        rd_en;

    always #4 clk = ~clk;  // 125 MHz

    sram_hex_reader i_sram_hex_reader (
        .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .mem_addr(mem_addr),
        .mem_dq(mem_dq), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .disp_seg_n(disp_seg_n)
    );

    // memory model: out-of-range addresses return a marker word
    assign model_word = (mem_addr[17:5] == 13'd0) ? mem[mem_addr[4:0]] : 16'hDEAD;
    assign rd_en      = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq[7:0]  = (rd_en && !mem_lb_n) ? model_word[7:0]  : 8'bz;
    assign mem_dq[15:8] = (rd_en && !mem_ub_n) ? model_word[15:8] : 8'bz;

    function automatic logic [6:0] glyph(input logic [3:0] v);
        logic [6:0] on;  // gfedcba, active high
        case (v)
            4'd0: on = 7'h3F; 4'd1: on = 7'h06; 4'd2: on = 7'h5B; 4'd3: on = 7'h4F;
            4'd4: on = 7'h66; 4'd5: on = 7'h6D; 4'd6: on = 7'h7D; 4'd7: on = 7'h07;
            4'd8: on = 7'h7F; 4'd9: on = 7'h6F; 4'd10: on = 7'h77; 4'd11: on = 7'h7C;
            4'd12: on = 7'h39; 4'd13: on = 7'h5E; 4'd14: on = 7'h79; default: on = 7'h71;
        endcase
        return ~on;
    endfunction

    function automatic logic [27:0] show(input logic [15:0] w);
        return {glyph(w[15:12]), glyph(w[11:8]), glyph(w[7:4]), glyph(w[3:0])};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_strobes(input logic lvl, input string req);
        check({mem_ce_n, mem_oe_n, mem_lb_n, mem_ub_n} == {4{lvl}}, req,
              {mem_ce_n, mem_oe_n, mem_lb_n, mem_ub_n}, {4{lvl}});
        check(mem_we_n == 1'b1, "R2", mem_we_n, 1);
    endtask

    // R4: reset from time zero
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(disp_seg_n == show(16'h0000), "R4", disp_seg_n, show(16'h0000));
        check_strobes(1'b1, "R4");
    endtask

    // R5: first edge after release arms strobes, display unchanged
    task automatic t_arm();
        sw_addr = 5'd7;
        rst_n = 1'b1;
        @(negedge clk);
        check_strobes(1'b0, "R5 R9");
        check(disp_seg_n == show(16'h0000), "R5", disp_seg_n, show(16'h0000));
    endtask

    // R1 R3 R6 R7 R8: read every location
    task automatic t_sweep();
        for (int a = 0; a < 32; a++) begin
            sw_addr = a[4:0];
            #1;
            check(mem_addr == {13'd0, a[4:0]}, "R1", mem_addr, a);
            @(negedge clk);
            check(disp_seg_n == show(mem[a]), "R6 R7 R8 R3", disp_seg_n, show(mem[a]));
            check_strobes(1'b0, "R9");
        end
    endtask

    // R4 R5: reset in mid-operation, then re-arm and capture
    task automatic t_mid_reset();
        sw_addr = 5'd3;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(disp_seg_n == show(16'h0000), "R4", disp_seg_n, show(16'h0000));
        check_strobes(1'b1, "R4");
        rst_n = 1'b1;
        @(negedge clk);
        check(disp_seg_n == show(16'h0000), "R5", disp_seg_n, show(16'h0000));
        check_strobes(1'b0, "R5");
        @(negedge clk);
        check(disp_seg_n == show(mem[3]), "R6", disp_seg_n, show(mem[3]));
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
        mem[0] = 16'h0000; mem[1] = 16'hFFFF; mem[2] = 16'h0123;
        mem[3] = 16'h4567; mem[4] = 16'h89AB; mem[5] = 16'hCDEF;
        mem[6] = 16'hFEDC; mem[7] = 16'h1E3D;
        t_reset();
        t_arm();
        t_sweep();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule